// File: doc/BRIEF.md
# Four-channel DMA register file

This block is the CPU-facing register set of a four-channel DMA controller. Software reaches it over a byte-wide I/O bus: a 4-bit port offset, a write strobe, a read strobe and 8-bit data in each direction. Each channel keeps a base and a current 16-bit address and a base and a current 16-bit transfer count. All of these sit behind 8-bit ports. A single byte-pointer bit, shared by every channel, picks the low or the high half on each access. Software loads a count one below the number of transfers it wants.

The remaining ports carry the control state: per-channel mode bytes, the channel masks, software requests, a command byte and a status byte. Some writes carry the target channel inside the data byte. A separate transfer engine reads the current addresses, counts, modes and masks. It returns updated current values and terminal-count pulses. A terminal count on a channel in auto-initialise mode copies the base values back into the current ones.

Top module: `dma_regfile`

## Requirements
- R1: After reset every mask bit is set (`mask_o` = 4'hF), `cmd_o` is 0, the byte pointer selects the low byte and a status read returns 8'h00.
- R2: A write to an address or count port loads the selected byte into both the base and the current copy. A read returns that byte of the current copy. The low byte comes first while the pointer is clear. Any read or write of ports 0 to 7 toggles the pointer.
- R3: A write of any value to port 4'hC clears the byte pointer, so the next 16-bit access hits the low byte.
- R4: Channel n's address register is at port 2n and its count register is at port 2n+1. `cur_addr_o[16n+15:16n]` and `cur_cnt_o[16n+15:16n]` show its current values.
- R5: A write to port 4'hA uses data bits 1:0 as the channel. Data bit 2 set masks that channel and data bit 2 clear unmasks it. The other mask bits keep their values.
- R6: A write to port 4'hB takes the channel from data bits 1:0 and stores data bits 7:2 in `mode_o[6n+5:6n]`. Mode bit 2 (data bit 4) is auto-initialise, mode bits 1:0 (data bits 3:2) are the direction (01 device to memory, 10 memory to device) and mode bits 5:4 (data bits 7:6) are the service kind (01 single, 11 cascade).
- R7: A write to port 4'hE clears all four mask bits. A write to port 4'hF loads all four from data bits 3:0.
- R8: A write to port 4'h8 loads `cmd_o` with the data byte. A read of port 4'h8 returns the status byte.
- R9: A write to port 4'hD is a master clear. It sets all mask bits and clears the pointer, command, request bits and terminal-count flags. A read of port 4'hD returns 8'h00.
- R10: Status bits 3:0 are per-channel terminal-count flags. A `tc_i` pulse sets its flag. A status read clears the flags after returning them. A pulse in the same cycle as that read survives into the next read.
- R11: Status bits 7:4 show the pending requests: the software request bits ORed with `dreq_i`. A write to port 4'h9 sets (data bit 2 = 1) or clears (data bit 2 = 0) the request of the channel in data bits 1:0.
- R12: `upd_en_i[n]` loads channel n's current address and count from `upd_addr_i` and `upd_cnt_i`. A `tc_i[n]` pulse on a channel whose mode bit 2 is set reloads both current values from the base values instead. Without that bit, the pulse leaves the current values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 4 | Port offset of the bus access |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd_stb` is high, otherwise 0 |
| dreq_i | input | 4 | Hardware request lines shown in status |
| tc_i | input | 4 | Terminal-count pulses from the engine |
| upd_en_i | input | 4 | Per-channel current-value update enable |
| upd_addr_i | input | 64 | Updated current addresses, 16 bits per channel |
| upd_cnt_i | input | 64 | Updated current counts, 16 bits per channel |
| cur_addr_o | output | 64 | Current addresses, 16 bits per channel |
| cur_cnt_o | output | 64 | Current counts, 16 bits per channel |
| mode_o | output | 24 | Stored mode fields, 6 bits per channel |
| mask_o | output | 4 | Channel mask bits |
| cmd_o | output | 8 | Command byte |

## Verification
The status read that clears the terminal-count flags can meet a fresh terminal-count pulse from the engine in the same cycle. The bench provokes this with one bus cycle that raises `rd_stb` on port 4'h8 and pulses `tc_i` for channel 3 together. It expects the byte returned in that cycle to hold only the earlier flags. The next status read must show channel 3's flag. A second overlap pairs an auto-initialise reload with an earlier engine update on the same channel, and the bench judges it by the base values reappearing on the current-value outputs.

// File: rtl/dma_regfile.sv
module dma_regfile (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  port_sel,
  input  logic        wr_stb,
  input  logic        rd_stb,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [3:0]  dreq_i,
  input  logic [3:0]  tc_i,
  input  logic [3:0]  upd_en_i,
  input  logic [63:0] upd_addr_i,
  input  logic [63:0] upd_cnt_i,
  output logic [63:0] cur_addr_o,
  output logic [63:0] cur_cnt_o,
  output logic [23:0] mode_o,
  output logic [3:0]  mask_o,
  output logic [7:0]  cmd_o
);
  localparam logic [3:0] P_CMD  = 4'h8;
  localparam logic [3:0] P_REQ  = 4'h9;
  localparam logic [3:0] P_MSK1 = 4'hA;
  localparam logic [3:0] P_MODE = 4'hB;
  localparam logic [3:0] P_PTR  = 4'hC;
  localparam logic [3:0] P_MCLR = 4'hD;
  localparam logic [3:0] P_MCLA = 4'hE;
  localparam logic [3:0] P_MALL = 4'hF;

  logic        ptr_hi;
  logic [3:0]  tc_flags;
  logic [3:0]  req_r;
  logic [15:0] base_a [4];
  logic [15:0] cur_a  [4];
  logic [15:0] base_c [4];
  logic [15:0] cur_c  [4];
  logic [5:0]  mode_r [4];

  wire wide_acc = (wr_stb | rd_stb) && !port_sel[3];
  wire mclr     = wr_stb && port_sel == P_MCLR;
  wire st_rd    = rd_stb && port_sel == P_CMD;
  wire [1:0] dch = wdata[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_hi   <= 1'b0;
      tc_flags <= '0;
      req_r    <= '0;
      mask_o   <= 4'hF;
      cmd_o    <= '0;
    end else if (mclr) begin
      ptr_hi   <= 1'b0;
      tc_flags <= '0;
      req_r    <= '0;
      mask_o   <= 4'hF;
      cmd_o    <= '0;
    end else begin
      if (wr_stb && port_sel == P_PTR) ptr_hi <= 1'b0;
      else if (wide_acc)               ptr_hi <= ~ptr_hi;
      tc_flags <= (st_rd ? 4'h0 : tc_flags) | tc_i;
      if (wr_stb) begin
        case (port_sel)
          P_CMD:  cmd_o       <= wdata;
          P_REQ:  req_r[dch]  <= wdata[2];
          P_MSK1: mask_o[dch] <= wdata[2];
          P_MCLA: mask_o      <= 4'h0;
          P_MALL: mask_o      <= wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_ch
    localparam logic [3:0] PA = 4'(2 * g);
    localparam logic [3:0] PC = 4'(2 * g + 1);
    wire wa = wr_stb && port_sel == PA;
    wire wc = wr_stb && port_sel == PC;
    wire reload = tc_i[g] && mode_r[g][2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_a[g] <= '0;
        cur_a[g]  <= '0;
      end else if (wa) begin
        if (ptr_hi) begin
          base_a[g][15:8] <= wdata;
          cur_a[g][15:8]  <= wdata;
        end else begin
          base_a[g][7:0] <= wdata;
          cur_a[g][7:0]  <= wdata;
        end
      end else if (reload) cur_a[g] <= base_a[g];
      else if (upd_en_i[g]) cur_a[g] <= upd_addr_i[16*g +: 16];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_c[g] <= '0;
        cur_c[g]  <= '0;
      end else if (wc) begin
        if (ptr_hi) begin
          base_c[g][15:8] <= wdata;
          cur_c[g][15:8]  <= wdata;
        end else begin
          base_c[g][7:0] <= wdata;
          cur_c[g][7:0]  <= wdata;
        end
      end else if (reload) cur_c[g] <= base_c[g];
      else if (upd_en_i[g]) cur_c[g] <= upd_cnt_i[16*g +: 16];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_r[g] <= '0;
      else if (wr_stb && port_sel == P_MODE && dch == 2'(g)) mode_r[g] <= wdata[7:2];
    end

    assign cur_addr_o[16*g +: 16] = cur_a[g];
    assign cur_cnt_o[16*g +: 16]  = cur_c[g];
    assign mode_o[6*g +: 6]       = mode_r[g];
  end

  logic [15:0] wide_val;
  logic [7:0]  rd_mux;
  assign wide_val = port_sel[0] ? cur_c[port_sel[2:1]] : cur_a[port_sel[2:1]];

  always_comb begin
    if (!port_sel[3])           rd_mux = ptr_hi ? wide_val[15:8] : wide_val[7:0];
    else if (port_sel == P_CMD) rd_mux = {req_r | dreq_i, tc_flags};
    else                        rd_mux = 8'h00;
  end

  assign rdata = rd_stb ? rd_mux : 8'h00;
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] port_sel,
  input logic       wr_stb,
  input logic       rd_stb,
  input logic [7:0] wdata,
  input logic [3:0] tc_i,
  input logic [3:0] mask_o,
  input logic [7:0] cmd_o,
  input logic       ptr_hi,
  input logic [3:0] tc_flags
);
  AST_MCLR_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && port_sel == 4'hD) |=> mask_o == 4'hF); // R9
  AST_CLR_ALL_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && port_sel == 4'hE) |=> mask_o == 4'h0); // R7
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && port_sel == 4'hC) |=> !ptr_hi); // R3
  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_stb || rd_stb) && !port_sel[3]) |=> ptr_hi != $past(ptr_hi)); // R2
  AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && port_sel == 4'h8) |=> cmd_o == $past(wdata)); // R8
  AST_TC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_i != 4'h0 && !(wr_stb && port_sel == 4'hD)) |=> (tc_flags & $past(tc_i)) == $past(tc_i)); // R10
endmodule

bind dma_regfile dma_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
  .wdata(wdata), .tc_i(tc_i), .mask_o(mask_o), .cmd_o(cmd_o),
  .ptr_hi(ptr_hi), .tc_flags(tc_flags)
);

// File: tb/test_dma_regfile.sv
module test_dma_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  port_sel = '0;
  logic        wr_stb = 1'b0;
  logic        rd_stb = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  dreq_i = '0;
  logic [3:0]  tc_i = '0;
  logic [3:0]  upd_en_i = '0;
  logic [63:0] upd_addr_i = '0;
  logic [63:0] upd_cnt_i = '0;
  logic [63:0] cur_addr_o;
  logic [63:0] cur_cnt_o;
  logic [23:0] mode_o;
  logic [3:0]  mask_o;
  logic [7:0]  cmd_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  dma_regfile i_dma_regfile (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_idle();
    @(posedge clk); #2;
    wr_stb = 0; rd_stb = 0; tc_i = '0; upd_en_i = '0;
  endtask

  task automatic wr(logic [3:0] p, logic [7:0] d);
    @(posedge clk); #2;
    port_sel = p; wdata = d; wr_stb = 1; rd_stb = 0; tc_i = '0; upd_en_i = '0;
  endtask

  task automatic rd(logic [3:0] p, logic [7:0] e, string tag, logic [3:0] tc = 4'h0);
    @(posedge clk); #2;
    port_sel = p; rd_stb = 1; wr_stb = 0; tc_i = tc; upd_en_i = '0;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic engine(logic [3:0] en, logic [3:0] tc, logic [63:0] a, logic [63:0] c);
    @(posedge clk); #2;
    wr_stb = 0; rd_stb = 0; upd_en_i = en; tc_i = tc; upd_addr_i = a; upd_cnt_i = c;
  endtask

  always @(negedge clk) begin
    if (rd_stb) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual %h expected none", rdata);
      end else begin
        check(tag_q.pop_front(), {24'h0, rdata}, {24'h0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    drive_idle();
    check("R1 mask", {28'h0, mask_o}, 32'hF);
    check("R1 cmd", {24'h0, cmd_o}, 32'h0);
    rd(4'h8, 8'h00, "R1 status");

    wr(4'hC, 8'h00); wr(4'h0, 8'h34); wr(4'h0, 8'h12); drive_idle();
    check("R2 addr0", {16'h0, cur_addr_o[15:0]}, 32'h1234);
    rd(4'h0, 8'h34, "R2 read low"); rd(4'h0, 8'h12, "R2 read high");

    wr(4'h5, 8'hFF); wr(4'h5, 8'h00); wr(4'h6, 8'hAA); wr(4'h6, 8'hBB); drive_idle();
    check("R4 cnt2", {16'h0, cur_cnt_o[47:32]}, 32'h00FF);
    check("R4 addr3", {16'h0, cur_addr_o[63:48]}, 32'hBBAA);

    wr(4'h0, 8'h55); wr(4'hC, 8'h00); wr(4'h1, 8'h77); wr(4'hC, 8'h00);
    rd(4'h1, 8'h77, "R3 cnt0 low"); rd(4'h1, 8'h00, "R3 cnt0 high");
    drive_idle();
    check("R3 addr0", {16'h0, cur_addr_o[15:0]}, 32'h1255);

    wr(4'hA, 8'h01); drive_idle();
    check("R5 unmask ch1", {28'h0, mask_o}, 32'hD);
    wr(4'hA, 8'h05); drive_idle();
    check("R5 mask ch1", {28'h0, mask_o}, 32'hF);
    wr(4'hE, 8'h00); drive_idle();
    check("R7 clear all", {28'h0, mask_o}, 32'h0);
    wr(4'hF, 8'h0A); drive_idle();
    check("R7 load all", {28'h0, mask_o}, 32'hA);

    wr(4'hB, 8'h4A); wr(4'hB, 8'h54); drive_idle();
    check("R6 mode ch2", {26'h0, mode_o[17:12]}, 32'h12);
    check("R6 mode ch0", {26'h0, mode_o[5:0]}, 32'h15);

    wr(4'h8, 8'hC3); drive_idle();
    check("R8 cmd", {24'h0, cmd_o}, 32'hC3);

    wr(4'h9, 8'h06); dreq_i = 4'b0001;
    rd(4'h8, 8'h50, "R11 status requests");
    wr(4'h9, 8'h02); dreq_i = 4'b0000;
    rd(4'h8, 8'h00, "R11 request cleared");

    engine(4'h0, 4'b0010, '0, '0);
    rd(4'h8, 8'h02, "R10 tc flag");
    rd(4'h8, 8'h00, "R10 cleared by read", 4'b1000);
    rd(4'h8, 8'h08, "R10 same-cycle tc kept");

    engine(4'b0011, 4'h0, {32'h0, 16'hBEEF, 16'h9999}, {32'h0, 16'h0010, 16'h0000});
    drive_idle();
    check("R12 upd addr1", {16'h0, cur_addr_o[31:16]}, 32'hBEEF);
    check("R12 upd cnt1", {16'h0, cur_cnt_o[31:16]}, 32'h0010);
    check("R12 upd addr0", {16'h0, cur_addr_o[15:0]}, 32'h9999);
    engine(4'h0, 4'b0101, '0, '0);
    drive_idle();
    check("R12 autoinit addr0", {16'h0, cur_addr_o[15:0]}, 32'h1255);
    check("R12 autoinit cnt0", {16'h0, cur_cnt_o[15:0]}, 32'h0077);
    check("R12 no reload ch2", {16'h0, cur_cnt_o[47:32]}, 32'h00FF);

    wr(4'h8, 8'h11); wr(4'hA, 8'h00); wr(4'h9, 8'h05);
    wr(4'h2, 8'h11); wr(4'hD, 8'h00); wr(4'h2, 8'h22); drive_idle();
    check("R9 mask", {28'h0, mask_o}, 32'hF);
    check("R9 cmd", {24'h0, cmd_o}, 32'h0);
    check("R9 pointer low", {16'h0, cur_addr_o[31:16]}, 32'hBE22);
    rd(4'h8, 8'h00, "R9 status");
    rd(4'hD, 8'h00, "R9 temp read");
    drive_idle();
    drive_idle();

    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule